// File: doc/BRIEF.md
# Quad 16-bit DAC Serial Register Controller

This block is the digital front end of a four-channel, 16-bit digital-to-analog converter. A host shifts command words in over a serial port: a clock, a data line, and an active-low select line that also acts as a load strobe. When the select line returns high, the block decodes the word. It then updates a per-channel input register and DAC register, or a per-channel power-down flag. The four DAC register values and the four power-down flags are the outputs that the analog section uses.

An asynchronous load strobe copies every input register into its DAC register. When the select line is low, the copy waits until the frame ends. Holding the load strobe low powers up all channels and blocks power-down commands. A level-sensitive clear line and a strap pin force all registers to either zero or mid-scale. The same strap pin sets the value that power-on reset loads. A serial output replays the shifted bits after 32 stages so that several devices can be daisy-chained.

All pins are sampled into one system clock through two-flop synchronizers, so the external serial clock must be much slower than the system clock. The serial port is a plain shift interface with no valid/ready handshake and no back-pressure: every qualified serial clock rising edge is accepted.

Top module: `quad_dac_ctrl`

## Requirements
- R1: A data bit is captured only on a serial-clock rising edge while the select line is low. While the select line is high, the serial clock changes neither the shift register nor the serial output.
- R2: The command runs when the select line rises, and only if exactly 24 or 32 bits were shifted. The last 24 bits form the word: bits [23:20] are the command, bits [19:16] the channel (0 to 3, with 4'hF meaning all channels), and bits [15:0] the data. In a 32-bit frame the 8 leading bits are ignored.
- R3: A frame of any other length is discarded, and no register changes.
- R4: The serial output changes only after a serial-clock falling edge, and only while the select line is low. After the falling edge that follows the k-th rising edge of a frame (k at least 32), it shows the bit captured at rising edge k-31.
- R5: Command 4'h0 writes the data into the input register of the selected channel(s). Command 4'h1 copies the selected input register(s) into the DAC register(s). Command 4'h2 writes the selected channel(s) and then copies all four channels. Command 4'h3 writes the selected channel(s) and copies those same channel(s).
- R6: Command 4'h4 sets the power-down flag of the selected channel(s), and command 4'h5 sets all four flags. Any copy into a channel's DAC register clears that channel's flag. All other command codes are no-ops.
- R7: A falling edge on the load strobe while the select line is high copies all four input registers into the DAC registers.
- R8: A load-strobe falling edge while the select line is low leaves the DAC registers unchanged until the select line rises. At that point all channels are copied, including any write made by that frame.
- R9: While the load strobe is low, every power-down flag is clear, and power-down commands have no effect.
- R10: While the clear line is low, every input and DAC register holds 16'h0000 if mid_sel is 0, or 16'h8000 if mid_sel is 1, and every power-down flag is clear.
- R11: After power-on reset, every register holds the value R10 gives for the current mid_sel, and every power-down flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| mid_sel | input | 1 | Strap: 1 selects mid-scale for reset and clear, 0 selects zero |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, MSB first |
| cs_ld_n | input | 1 | Active-low select; its rising edge executes the frame |
| ldac_n | input | 1 | Active-low asynchronous load strobe |
| clr_n | input | 1 | Active-low level-sensitive clear |
| sdo | output | 1 | Daisy-chain serial output |
| dac_codes | output | 64 | Four DAC register values, channel 0 in bits [15:0] |
| pwr_dn | output | 4 | Per-channel power-down flags |

## Verification
The assertions assume that mid_sel is a static strap that changes only while reset is held. They also assume that every pin is held for several system clocks, so that each level survives the synchronizers and forms a clean edge. The bench keeps every serial clock phase six system cycles long. It holds each load and clear pulse for eight cycles, and changes data only while the serial clock is low. It changes mid_sel only with rst_n low or between clear pulses, never while clear is active.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int DATA_W  = 16;
  localparam int CH_N    = 4;
  localparam int OP_W    = 4;
  localparam int SEL_W   = 4;
  localparam int LONG_W  = 32;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE       = 4'h0,
    OP_UPDATE      = 4'h1,
    OP_WRITE_ALL   = 4'h2,
    OP_WRITE_UPD   = 4'h3,
    OP_PDOWN       = 4'h4,
    OP_PDOWN_ALL   = 4'h5,
    OP_NOP         = 4'hF
  } op_e;
endpackage

// File: rtl/qdac_edge_sync.sv
module qdac_edge_sync #(
  parameter int          N   = 5,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, stab_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= IDLE[g];
        stab_q[g] <= IDLE[g];
        prev_q[g] <= IDLE[g];
      end else begin
        meta_q[g] <= pin_i[g];
        stab_q[g] <= meta_q[g];
        prev_q[g] <= stab_q[g];
      end
    end
    assign lvl_o[g]  = stab_q[g];
    assign rise_o[g] = stab_q[g] & ~prev_q[g];
    assign fall_o[g] = ~stab_q[g] & prev_q[g];
  end
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int SR_W   = 32,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_low,
  input  logic              cs_rise,
  input  logic              sdi_s,
  output logic              sdo,
  output logic              frame_ok,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(SR_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SR_W + 1);

  logic [SR_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;
  logic             sdo_q;
  logic             take;

  assign take = sck_rise & cs_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (take) begin
        shreg <= {shreg[SR_W-2:0], sdi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
      if (cs_rise) cnt <= '0;
      if (sck_fall && cs_low) sdo_q <= shreg[SR_W-1];
    end
  end

  assign sdo      = sdo_q;
  assign word     = shreg[WORD_W-1:0];
  assign frame_ok = cs_rise && (cnt == CNT_W'(WORD_W) || cnt == CNT_W'(SR_W));

  AST_SCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> $stable(shreg)); // R1
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(sck_fall && cs_low)); // R4
endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank
  import qdac_pkg::*;
#(
  parameter int NCH = CH_N,
  parameter int DW  = DATA_W,
  parameter int AW  = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_sel,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data,
  input  logic              cs_high,
  input  logic              cs_rise,
  input  logic              ldac_fall,
  input  logic              ldac_low,
  input  logic              clr_active,
  output logic [NCH*DW-1:0] dac_flat,
  output logic [NCH-1:0]    pd_o
);
  localparam logic [AW-1:0] ADDR_ALL = '1;

  logic [DW-1:0]  in_q   [NCH];
  logic [DW-1:0]  dac_q  [NCH];
  logic [DW-1:0]  in_nxt [NCH];
  logic [DW-1:0]  dac_nxt[NCH];
  logic [NCH-1:0] pd_q, pd_nxt, sel, upd, pd_set;
  logic [NCH*DW-1:0] in_flat;
  logic           pend_q, pend_nxt, load_all;
  logic [DW-1:0]  rst_val;

  assign rst_val  = mid_sel ? {1'b1, {(DW-1){1'b0}}} : '0;
  assign load_all = (ldac_fall && cs_high) || (cs_rise && pend_q);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sel[g] = (addr == ADDR_ALL) || (addr == AW'(g));
    assign dac_flat[g*DW +: DW] = dac_q[g];
    assign in_flat[g*DW +: DW]  = in_q[g];
  end

  always_comb begin
    upd    = '0;
    pd_set = '0;
    for (int i = 0; i < NCH; i++) begin
      in_nxt[i]  = in_q[i];
      dac_nxt[i] = dac_q[i];
    end
    if (cmd_valid) begin
      case (cmd)
        OP_WRITE: begin
          for (int i = 0; i < NCH; i++) if (sel[i]) in_nxt[i] = data;
        end
        OP_UPDATE:    upd = sel;
        OP_WRITE_ALL: begin
          for (int i = 0; i < NCH; i++) if (sel[i]) in_nxt[i] = data;
          upd = '1;
        end
        OP_WRITE_UPD: begin
          for (int i = 0; i < NCH; i++) if (sel[i]) in_nxt[i] = data;
          upd = sel;
        end
        OP_PDOWN:     pd_set = sel;
        OP_PDOWN_ALL: pd_set = '1;
        default: ;
      endcase
    end
    if (load_all) upd = '1;
    pd_nxt = pd_q;
    for (int i = 0; i < NCH; i++) begin
      if (upd[i]) begin
        dac_nxt[i] = in_nxt[i];
        pd_nxt[i]  = 1'b0;
      end
    end
    pd_nxt = ldac_low ? '0 : (pd_nxt | pd_set);
    if (cs_rise)                      pend_nxt = 1'b0;
    else if (ldac_fall && !cs_high)   pend_nxt = 1'b1;
    else                              pend_nxt = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_q[i]  <= rst_val;
        dac_q[i] <= rst_val;
      end
      pd_q   <= '0;
      pend_q <= 1'b0;
    end else if (clr_active) begin
      for (int i = 0; i < NCH; i++) begin
        in_q[i]  <= rst_val;
        dac_q[i] <= rst_val;
      end
      pd_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        in_q[i]  <= in_nxt[i];
        dac_q[i] <= dac_nxt[i];
      end
      pd_q   <= pd_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign pd_o = pd_q;

  AST_CLR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |=> dac_flat == {NCH{$past(rst_val)}}); // R10
  AST_LDAC_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_low |=> pd_o == '0); // R9
  AST_DEFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && !cs_high && !clr_active) |=> $stable(dac_flat)); // R8
  AST_DROP_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !clr_active) |=> $stable(in_flat)); // R3
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import qdac_pkg::*;
#(
  parameter int NCH = CH_N,
  parameter int DW  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_sel,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cs_ld_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic [NCH*DW-1:0] dac_codes,
  output logic [NCH-1:0]    pwr_dn
);
  localparam int WORD_W = OP_W + SEL_W + DW;
  localparam int PIN_N  = 5;
  // pin order: 0 sck, 1 sdi, 2 select, 3 load strobe, 4 clear
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11100;

  logic [PIN_N-1:0] pins, lvl, rise, fall;
  logic             frame_ok, cs_low;
  logic [WORD_W-1:0] word;

  assign pins   = {clr_n, ldac_n, cs_ld_n, sdi, sck};
  assign cs_low = ~lvl[2];

  qdac_edge_sync #(.N(PIN_N), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  qdac_shifter #(.SR_W(LONG_W), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(rise[0]), .sck_fall(fall[0]),
    .cs_low(cs_low), .cs_rise(rise[2]), .sdi_s(lvl[1]),
    .sdo(sdo), .frame_ok(frame_ok), .word(word)
  );

  qdac_reg_bank #(.NCH(NCH), .DW(DW), .AW(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel),
    .cmd_valid(frame_ok),
    .cmd(word[WORD_W-1 -: OP_W]),
    .addr(word[DW +: SEL_W]),
    .data(word[DW-1:0]),
    .cs_high(lvl[2]), .cs_rise(rise[2]),
    .ldac_fall(fall[3]), .ldac_low(~lvl[3]),
    .clr_active(~lvl[4]),
    .dac_flat(dac_codes), .pd_o(pwr_dn)
  );
endmodule

// File: tb/quad_dac_ctrl_bench.sv
module quad_dac_ctrl_bench;
  localparam int PH = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0, mid_sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic cs_ld_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [63:0] dac_codes;
  logic [3:0]  pwr_dn;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_in [4];
  logic [15:0] m_dac[4];
  logic [3:0]  m_pd;

  always #2 clk = ~clk;

  quad_dac_ctrl u_quad_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .sck(sck), .sdi(sdi),
    .cs_ld_n(cs_ld_n), .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo),
    .dac_codes(dac_codes), .pwr_dn(pwr_dn)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 4; i++) chk(req, 32'(dac_codes[i*16 +: 16]), 32'(m_dac[i]));
    chk(req, 32'(pwr_dn), 32'(m_pd));
  endtask

  task automatic model_fill(input logic [15:0] v);
    for (int i = 0; i < 4; i++) begin m_in[i] = v; m_dac[i] = v; end
    m_pd = '0;
  endtask

  task automatic model_load_all();
    for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    m_pd = '0;
  endtask

  task automatic model_cmd(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d,
                           input bit ldac_low);
    logic [3:0] s;
    for (int i = 0; i < 4; i++) s[i] = (a == 4'hF) || (a == 4'(i));
    case (c)
      4'h0: for (int i = 0; i < 4; i++) if (s[i]) m_in[i] = d;
      4'h1: for (int i = 0; i < 4; i++) if (s[i]) begin m_dac[i] = m_in[i]; m_pd[i] = 0; end
      4'h2: begin
        for (int i = 0; i < 4; i++) if (s[i]) m_in[i] = d;
        model_load_all();
      end
      4'h3: for (int i = 0; i < 4; i++) if (s[i]) begin
        m_in[i] = d; m_dac[i] = d; m_pd[i] = 0;
      end
      4'h4: if (!ldac_low) m_pd = m_pd | s;
      4'h5: if (!ldac_low) m_pd = '1;
      default: ;
    endcase
  endtask

  task automatic send_frame(input int n, input logic [63:0] v, input bit mid_ldac,
                            input bit chk_sdo);
    cs_ld_n = 1'b0;
    wait_clk(PH);
    for (int k = 1; k <= n; k++) begin
      sdi = v[n-k];
      wait_clk(PH);
      sck = 1'b1;
      wait_clk(PH);
      sck = 1'b0;
      if (mid_ldac && k == n/2) begin
        ldac_n = 1'b0; wait_clk(8); ldac_n = 1'b1; wait_clk(8);
        chk_all("R8 held while selected");
      end
      wait_clk(PH);
      if (chk_sdo && k >= 32) chk("R4 sdo delay", 32'(sdo), 32'(v[n-(k-31)]));
    end
    cs_ld_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic do_cmd(input int n, input logic [3:0] c, input logic [3:0] a,
                        input logic [15:0] d, input logic [7:0] pad);
    send_frame(n, {32'h0, pad, c, a, d}, 0, 0);
    if (n == 24 || n == 32) model_cmd(c, a, d, !ldac_n);
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [7] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'hF};
    logic [3:0] ads [5] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hF};
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    model_fill(16'h0000);
    chk_all("R11 reset zero");
    chk("R4 sdo reset", 32'(sdo), 0);

    // R2 R5 R6 sweep, alternating 24- and 32-bit frames
    for (int ci = 0; ci < 7; ci++) begin
      for (int ai = 0; ai < 5; ai++) begin
        logic [15:0] d;
        d = 16'((ci * 37 + ai * 911 + 5) * 97);
        do_cmd(((ci + ai) % 2 == 0) ? 24 : 32, ops[ci], ads[ai], d, 8'(ci * 29 + 3));
        chk_all("R2 R5 R6 sweep");
      end
    end

    // R3 bad lengths
    foreach (ads[j]) begin
      int n;
      n = (j == 0) ? 23 : (j == 1) ? 25 : (j == 2) ? 31 : (j == 3) ? 33 : 1;
      do_cmd(n, 4'h3, 4'hF, 16'h5A5A, 8'h00);
      chk_all("R3 bad length");
    end
    do_cmd(24, 4'h5, 4'h0, 16'h0, 8'h00);
    chk_all("R6 power down all");

    // R1 serial clock ignored while select high
    for (int k = 0; k < 10; k++) begin
      sdi = k[0]; wait_clk(PH); sck = 1'b1; wait_clk(PH); sck = 1'b0;
    end
    wait_clk(PH);
    cs_ld_n = 1'b0; wait_clk(PH); cs_ld_n = 1'b1; wait_clk(12);
    chk_all("R1 sck ignored with select high");

    // R7 immediate load
    do_cmd(24, 4'h0, 4'h2, 16'h1234, 8'h00);
    chk_all("R7 before strobe");
    ldac_n = 1'b0; wait_clk(8); ldac_n = 1'b1; wait_clk(6);
    model_load_all();
    chk_all("R7 load on strobe");

    // R8 deferred load
    send_frame(24, {40'h0, 4'h0, 4'h1, 16'hABCD}, 1, 0);
    model_cmd(4'h0, 4'h1, 16'hABCD, 0);
    model_load_all();
    chk_all("R8 deferred load");

    // R9 power down blocked while strobe low
    ldac_n = 1'b0; wait_clk(8);
    model_load_all();
    do_cmd(32, 4'h5, 4'h0, 16'h0, 8'hFF);
    chk_all("R9 power down ignored");
    ldac_n = 1'b1; wait_clk(8);
    do_cmd(24, 4'h4, 4'h3, 16'h0, 8'h00);
    chk_all("R9 power down accepted");
    ldac_n = 1'b0; wait_clk(8);
    model_load_all();
    chk_all("R9 strobe powers up");
    ldac_n = 1'b1; wait_clk(8);

    // R4 daisy chain
    send_frame(48, 64'h0000_C3A5_96F0_1E87, 0, 1);
    chk_all("R3 48-bit frame dropped");

    // R10 clear to mid-scale then zero
    mid_sel = 1'b1;
    clr_n = 1'b0; wait_clk(8);
    model_fill(16'h8000);
    chk_all("R10 clear mid");
    clr_n = 1'b1; wait_clk(6);
    do_cmd(24, 4'h3, 4'h0, 16'h0F0F, 8'h00);
    chk_all("R10 after clear");
    mid_sel = 1'b0; wait_clk(2);
    clr_n = 1'b0; wait_clk(8);
    model_fill(16'h0000);
    chk_all("R10 clear zero");
    clr_n = 1'b1; wait_clk(6);

    // R11 reset with mid-scale strap
    rst_n = 1'b0; mid_sel = 1'b1; wait_clk(4);
    rst_n = 1'b1; wait_clk(4);
    model_fill(16'h8000);
    chk_all("R11 reset mid");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule